// File: doc/BRIEF.md
# Supply Supervisor with Auto-Restart

This block decides whether the power stage of a switching converter may switch. It watches a digitised supply-voltage code, a temperature-alarm flag that arrives from another clock domain, and a one-millisecond tick. From these it drives three outputs: a switching permission, an enable for the high-voltage startup current source, and a two-bit record of the last fault cause.

Under-voltage lockout gives it hysteresis. Switching is allowed once the supply climbs to the turn-on code. It is withdrawn only when the supply sinks to the much lower turn-off code. An over-voltage condition counts only after it has held for a debounce window of millisecond ticks. Over-voltage and over-temperature share one recovery path. Switching stops, the controller waits for the supply to run down to the turn-off code, the startup source is re-armed, and switching returns when the turn-on code is reached again. While the fault persists, this loop keeps repeating.

Top module: `supply_supervisor`

## Requirements
- R1: During and right after reset, the block is in the charging state: `switch_en` = 0, `startup_en` = 1, `fault_cause` = 2'b00.
- R2: In the charging state, `switch_en` stays 0 while `supply_code` < ON_LEVEL (default 160). On the first clock edge that sees `supply_code` >= ON_LEVEL, `switch_en` becomes 1 and `startup_en` becomes 0.
- R3: While switching and with no fault, the block keeps switching for any `supply_code` above OFF_LEVEL (default 50). On the edge that sees `supply_code` <= OFF_LEVEL, it returns to charging with `switch_en` = 0 and `startup_en` = 1.
- R4: An over-voltage fault is declared when `supply_code` > OVP_LEVEL (default 240) holds through DEBOUNCE_TICKS (default 200) asserted `ms_tick` cycles. After 199 such ticks, switching is still on. One clock edge after the tick that completes the window, `switch_en` is 0.
- R5: The debounce count restarts from zero whenever a clock edge sees `supply_code` <= OVP_LEVEL before the window completes.
- R6: On a fault, `switch_en` and `startup_en` are both 0. They stay 0 while `supply_code` > OFF_LEVEL. Once `supply_code` <= OFF_LEVEL, the block returns to charging with `startup_en` = 1.
- R7: `fault_cause` is bit 0 for over-voltage and bit 1 for over-temperature, so 2'b01 means over-voltage, 2'b10 means over-temperature, and 2'b11 means both were seen on the same edge. The value is held through the wait and charging phases and cleared to 2'b00 on the edge that re-enters switching.
- R8: `hot_flag_async` passes through a two-flop synchronizer. When it is set before edge 1 during switching, `switch_en` is still 1 after edge 2 and is 0 after edge 3.
- R9: If the over-temperature flag stays set, each return to the turn-on code gives exactly one cycle of switching before the fault trips again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_code | input | VCODE_W (8) | Supply voltage code |
| hot_flag_async | input | 1 | Over-temperature alarm, asynchronous |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| switch_en | output | 1 | Switching permission |
| startup_en | output | 1 | Startup current source enable |
| fault_cause | output | 2 | Latched fault cause, {temperature, voltage} |

## Verification
The over-voltage window and the synchronized temperature alarm can both mature on the same clock edge. The bench provokes this by delivering 199 debounce ticks, then raising the temperature flag one cycle before the final tick. The two-flop delay then lands both conditions on one edge. The scoreboard expects `fault_cause` = 2'b11 with switching stopped, which shows that neither cause masked the other.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [1:0] {
      ST_CHARGING       = 2'd0,
      ST_RUN            = 2'd1,
      ST_FAULT_WAIT     = 2'd2,
      ST_DISCHARGE_WAIT = 2'd3
   } sup_state_e;

   localparam int CAUSE_W = 2;
   localparam int CAUSE_OV_BIT = 0;
   localparam int CAUSE_OT_BIT = 1;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sup_ovp_debounce.sv
module sup_ovp_debounce #(
   parameter int VCODE_W        = 8,
   parameter int OVP_LEVEL      = 240,
   parameter int DEBOUNCE_TICKS = 200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VCODE_W-1:0] supply_code,
   input  logic               ms_tick,
   output logic               ovp_hit
);
   localparam int CW = $clog2(DEBOUNCE_TICKS + 1);
   localparam logic [CW-1:0]      LIMIT = CW'(DEBOUNCE_TICKS);
   localparam logic [VCODE_W-1:0] OVP_C = VCODE_W'(OVP_LEVEL);

   if (DEBOUNCE_TICKS < 1) begin : g_bad_deb
      $error("sup_ovp_debounce: DEBOUNCE_TICKS must be positive");
   end

   logic          over;
   logic [CW-1:0] cnt_q;

   assign over = supply_code > OVP_C;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!over)                    cnt_q <= '0;
      else if (ms_tick && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign ovp_hit = (cnt_q == LIMIT);

   // R4
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(over && ms_tick));

   // R5
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !over |=> (cnt_q == '0));
endmodule

// File: rtl/sup_restart_fsm.sv
module sup_restart_fsm
   import sup_pkg::*;
#(
   parameter int VCODE_W   = 8,
   parameter int ON_LEVEL  = 160,
   parameter int OFF_LEVEL = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VCODE_W-1:0] supply_code,
   input  logic               ovp_hit,
   input  logic               hot_sync,
   output logic               switch_en,
   output logic               startup_en,
   output logic [CAUSE_W-1:0] fault_cause
);
   localparam logic [VCODE_W-1:0] ON_C  = VCODE_W'(ON_LEVEL);
   localparam logic [VCODE_W-1:0] OFF_C = VCODE_W'(OFF_LEVEL);

   sup_state_e         state_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               at_on, at_off, fault_now;

   assign at_on     = supply_code >= ON_C;
   assign at_off    = supply_code <= OFF_C;
   assign fault_now = ovp_hit | hot_sync;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_CHARGING;
         cause_q <= '0;
      end else begin
         unique case (state_q)
            ST_CHARGING: if (at_on) begin
               state_q <= ST_RUN;
               cause_q <= '0;
            end
            ST_RUN: if (fault_now) begin
               state_q <= ST_FAULT_WAIT;
               cause_q[CAUSE_OV_BIT] <= ovp_hit;
               cause_q[CAUSE_OT_BIT] <= hot_sync;
            end else if (at_off) begin
               state_q <= ST_CHARGING;
            end
            ST_FAULT_WAIT:     state_q <= ST_DISCHARGE_WAIT;
            ST_DISCHARGE_WAIT: if (at_off) state_q <= ST_CHARGING;
            default:           state_q <= ST_CHARGING;
         endcase
      end
   end

   assign switch_en   = (state_q == ST_RUN);
   assign startup_en  = (state_q == ST_CHARGING);
   assign fault_cause = cause_q;

   // R6
   fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_en && fault_now) |=> (!switch_en && !startup_en));

   // R3
   uvlo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_en && !fault_now && at_off) |=> (!switch_en && startup_en));

   // R7
   cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(switch_en) |-> (fault_cause == '0));

   // R6
   discharge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DISCHARGE_WAIT && !at_off) |=> (!switch_en && !startup_en));

   // R2
   no_early_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (startup_en && !at_on) |=> !switch_en);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
   parameter int VCODE_W        = 8,
   parameter int ON_LEVEL       = 160,
   parameter int OFF_LEVEL      = 50,
   parameter int OVP_LEVEL      = 240,
   parameter int DEBOUNCE_TICKS = 200,
   parameter int SYNC_STAGES    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VCODE_W-1:0] supply_code,
   input  logic               hot_flag_async,
   input  logic               ms_tick,
   output logic               switch_en,
   output logic               startup_en,
   output logic [1:0]         fault_cause
);
   if (!(OFF_LEVEL < ON_LEVEL && ON_LEVEL < OVP_LEVEL)) begin : g_bad_levels
      $error("supply_supervisor: need OFF_LEVEL < ON_LEVEL < OVP_LEVEL");
   end
   if (OVP_LEVEL >= (1 << VCODE_W)) begin : g_bad_width
      $error("supply_supervisor: OVP_LEVEL exceeds code range");
   end

   logic hot_sync, ovp_hit;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign hot_sync = hot_flag_async;
   end else begin : g_sync
      sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_async(hot_flag_async), .q_sync(hot_sync)
      );
   end

   sup_ovp_debounce #(
      .VCODE_W(VCODE_W), .OVP_LEVEL(OVP_LEVEL), .DEBOUNCE_TICKS(DEBOUNCE_TICKS)
   ) u_ovp (
      .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
      .ms_tick(ms_tick), .ovp_hit(ovp_hit)
   );

   sup_restart_fsm #(
      .VCODE_W(VCODE_W), .ON_LEVEL(ON_LEVEL), .OFF_LEVEL(OFF_LEVEL)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
      .ovp_hit(ovp_hit), .hot_sync(hot_sync),
      .switch_en(switch_en), .startup_en(startup_en), .fault_cause(fault_cause)
   );
endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] supply_code = 8'd0;
   logic       hot_flag_async = 1'b0;
   logic       ms_tick = 1'b0;
   logic       switch_en, startup_en;
   logic [1:0] fault_cause;

   typedef struct {
      string    req;
      bit       sw;
      bit       st;
      bit [1:0] fc;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   supply_supervisor uut (
      .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
      .hot_flag_async(hot_flag_async), .ms_tick(ms_tick),
      .switch_en(switch_en), .startup_en(startup_en), .fault_cause(fault_cause)
   );

   task automatic expect_out(string r, bit sw, bit st, bit [1:0] fc);
      exp_t e;
      e.req = r; e.sw = sw; e.st = st; e.fc = fc;
      q.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         @(negedge clk); ms_tick = 1'b1;
         @(negedge clk); ms_tick = 1'b0;
      end
   endtask

   // monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (switch_en !== e.sw || startup_en !== e.st || fault_cause !== e.fc) begin
               n_fail++;
               $display("FAIL %s: got sw=%0b st=%0b cause=%b, expected sw=%0b st=%0b cause=%b",
                        e.req, switch_en, startup_en, fault_cause, e.sw, e.st, e.fc);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      step(3);
      expect_out("R1 reset", 0, 1, 2'b00);
      step(1); rst_n = 1'b1;
      supply_code = 8'd100; step(3);
      expect_out("R2 below on level", 0, 1, 2'b00);
      supply_code = 8'd160; step(1);
      expect_out("R2 enter run", 1, 0, 2'b00);
      supply_code = 8'd100; step(3);
      expect_out("R3 hysteresis hold", 1, 0, 2'b00);
      supply_code = 8'd50; step(1);
      expect_out("R3 uvlo to charging", 0, 1, 2'b00);
      supply_code = 8'd170; step(1);
      expect_out("R2 re-enter run", 1, 0, 2'b00);

      // over-voltage with an interruption that must restart the count
      supply_code = 8'd250; ticks(150);
      supply_code = 8'd200; step(1);
      supply_code = 8'd250; ticks(199);
      expect_out("R5 debounce restarted", 1, 0, 2'b00);
      ticks(1); step(1);
      expect_out("R4 ovp fault", 0, 0, 2'b01);
      supply_code = 8'd100; step(3);
      expect_out("R6 wait discharge", 0, 0, 2'b01);
      supply_code = 8'd50; step(2);
      expect_out("R7 cause held while charging", 0, 1, 2'b01);
      supply_code = 8'd160; step(1);
      expect_out("R7 cause cleared on run", 1, 0, 2'b00);

      // over-temperature through synchronizer
      hot_flag_async = 1'b1; step(2);
      expect_out("R8 sync latency", 1, 0, 2'b00);
      step(1);
      expect_out("R8 ot fault", 0, 0, 2'b10);
      supply_code = 8'd40; step(2);
      expect_out("R9 restart charging", 0, 1, 2'b10);
      supply_code = 8'd165; step(1);
      expect_out("R9 one run cycle", 1, 0, 2'b00);
      step(1);
      expect_out("R9 fault again", 0, 0, 2'b10);

      // both causes on one edge
      hot_flag_async = 1'b0;
      supply_code = 8'd40; step(3);
      supply_code = 8'd170; step(1);
      expect_out("R2 run after clear", 1, 0, 2'b00);
      supply_code = 8'd250; ticks(199);
      hot_flag_async = 1'b1;
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
      step(1);
      expect_out("R7 both causes", 0, 0, 2'b11);

      step(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule